// File: doc/BRIEF.md
# Keyed-Command Watchdog Timer

This block is a watchdog built around a 20-bit down-counter. The counter moves on a slow tick enable that stands for a 90 kHz time base, so a full-scale count lasts roughly 11.65 seconds. Software reaches the block through two 32-bit word registers: control at offset 0x00 and count at offset 0x04. The only way to command the block is to write an exact 16-bit key word to control. The keys halt or resume the countdown, open or seal the count register, refill the counter to full scale, and acknowledge the interrupt.

The count register accepts a value only while it is open. The written value lands in counter bits [19:4], and bits [3:0] become zero. A read of the count register returns counter bits [19:4]. When a running counter steps from one to zero, the block sets a sticky interrupt and sends a one-cycle reset request to the system reset controller. The counter then stays at zero.

A forced restart is built from the keys. Software halts the counter, opens the count register, writes 1, seals it and resumes. The watchdog then fires 16 ticks later.

The register port is a plain single-cycle write strobe with a combinational read mux. It has no back-pressure. Every write is taken on the clock edge where the strobe is sampled.

Top module: `kwdt_top`

## Requirements
- R1: After reset the counter is halted, the count register is sealed, the counter holds 0xFFFFF (so a count read returns 0xFFFF), and both the interrupt and the reset request are low.
- R2: Writing 0x00003877 to control (address 0x00) halts the countdown. While halted, ticks leave the counter unchanged. Writing 0x00004A4B resumes the countdown from the value the counter holds.
- R3: Writing 0x0000AB00 to control opens the count register, and writing 0x0000AB01 seals it again. A write to the count register (address 0x04) while it is sealed leaves the counter unchanged.
- R4: A write to the open count register sets counter[19:4] to wdata[15:0] and counter[3:0] to zero, whether the counter is running or halted. This load wins over a tick in the same cycle.
- R5: A read at address 0x04 returns counter[19:4] in bits [15:0] and zero in bits [31:16]. A read at any other address returns zero.
- R6: Writing 0x0000DEAF to control sets the counter to 0xFFFFF even while the count register is sealed.
- R7: While running, each cycle with the tick enable high lowers a nonzero counter by exactly one. A cycle without a tick leaves it unchanged.
- R8: A tick that takes a running counter from 1 to 0 sets the interrupt and raises the reset request for exactly one cycle, in the cycle after that edge. The counter then holds at zero, and no further reset request follows. A counter loaded with zero never fires.
- R9: Writing 0x00007482 to control clears the interrupt. If an expiry happens in the same cycle, the interrupt stays set.
- R10: A control write whose bits [15:0] match no key, or whose bits [31:16] are not zero, has no effect on any state.
- R11: The sequence halt, open, write count 1, seal, resume makes the reset request rise after exactly 16 further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle time-base enable for the countdown |
| bus_we | input | 1 | Register write strobe, taken on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_irq | output | 1 | Sticky expiry interrupt |
| wdt_rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
A write or tick sampled on a rising edge updates the state on that same edge. The count readback reflects the new value right away, because the read mux is combinational. The interrupt and the reset request are registered, so they rise on the edge where the final tick is sampled. The bench applies each stimulus at a falling edge and compares outputs at the next falling edge, exactly one cycle later. Its model follows the same order: it advances at the rising edge, before the comparison.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned KEY_W   = 16;
  localparam int unsigned N_KEYS  = 6;

  // Index of each command in the decoded hit vector
  localparam int unsigned K_HALT = 0;
  localparam int unsigned K_RUN  = 1;
  localparam int unsigned K_OPEN = 2;
  localparam int unsigned K_SEAL = 3;
  localparam int unsigned K_FILL = 4;
  localparam int unsigned K_ACK  = 5;

  function automatic logic [KEY_W-1:0] key_word(input int unsigned idx);
    case (idx)
      K_HALT:  key_word = 16'h3877;
      K_RUN:   key_word = 16'h4A4B;
      K_OPEN:  key_word = 16'hAB00;
      K_SEAL:  key_word = 16'hAB01;
      K_FILL:  key_word = 16'hDEAF;
      default: key_word = 16'h7482;
    endcase
  endfunction

  typedef struct packed {
    logic halt;
    logic run;
    logic open;
    logic seal;
    logic fill;
    logic ack;
  } kwdt_cmd_t;
endpackage

// File: rtl/kwdt_keydec.sv
module kwdt_keydec
  import kwdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output kwdt_cmd_t         cmd
);
  localparam int unsigned HI_W = DATA_W - KEY_W;

  logic              upper_clear;
  logic [N_KEYS-1:0] hit;

  assign upper_clear = (wdata[DATA_W-1:KEY_W] == {HI_W{1'b0}});

  for (genvar k = 0; k < N_KEYS; k++) begin : g_key
    assign hit[k] = ctrl_wr && upper_clear && (wdata[KEY_W-1:0] == key_word(k));
  end

  assign cmd.halt = hit[K_HALT];
  assign cmd.run  = hit[K_RUN];
  assign cmd.open = hit[K_OPEN];
  assign cmd.seal = hit[K_SEAL];
  assign cmd.fill = hit[K_FILL];
  assign cmd.ack  = hit[K_ACK];

  // R10: at most one command per write, none without a write
  a_r10_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  a_r10_no_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |-> (hit == '0));
endmodule

// File: rtl/kwdt_lock.sv
module kwdt_lock
  import kwdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  kwdt_cmd_t cmd,
  input  logic      cnt_wr,
  output logic      open_q,
  output logic      load_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        open_q <= 1'b0;
    else if (cmd.open) open_q <= 1'b1;
    else if (cmd.seal) open_q <= 1'b0;
  end

  assign load_en = cnt_wr && open_q;

  // R3: the window changes state only on its keys
  a_r3_window_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.open && !cmd.seal) |=> $stable(open_q));
  a_r3_seal_closes: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.seal |=> !open_q);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned VIS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  kwdt_cmd_t        cmd,
  input  logic             load_en,
  input  logic [VIS_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             expire
);
  localparam int unsigned LOW_W = CNT_W - VIS_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic step;

  always_comb begin
    step   = run_q && tick_en && (cnt_q != '0) && !load_en && !cmd.fill;
    expire = step && (cnt_q == CNT_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= CNT_MAX;
    else if (load_en)  cnt_q <= {load_val, {LOW_W{1'b0}}};
    else if (cmd.fill) cnt_q <= CNT_MAX;
    else if (step)     cnt_q <= cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (cmd.halt) run_q <= 1'b0;
    else if (cmd.run)  run_q <= 1'b1;
  end

  // R2: halted counter does not move unless loaded
  a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_en && !cmd.fill) |=> $stable(cnt_q));
  // R7: one step per tick while running
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && cnt_q != '0 && !load_en && !cmd.fill)
      |=> (cnt_q == $past(cnt_q) - CNT_ONE));
  // R8: zero is held
  a_r8_zero_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_en && !cmd.fill) |=> (cnt_q == '0));
  // R6: fill reaches full scale
  a_r6_fill_max: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.fill && !load_en) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/kwdt_alarm.sv
module kwdt_alarm
  import kwdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      expire,
  input  kwdt_cmd_t cmd,
  output logic      irq_q,
  output logic      rst_req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= expire;
      if (expire)       irq_q <= 1'b1;
      else if (cmd.ack) irq_q <= 1'b0;
    end
  end

  // R8: reset request is a single-cycle pulse and always carries the interrupt
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);
  a_r8_req_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> irq_q);
  // R9: interrupt sticks until acknowledged
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !cmd.ack) |=> irq_q);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq_q);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned VIS_W    = 16,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned CNT_OFS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_OFS);
  localparam int unsigned LOW_W = CNT_W - VIS_W;
  localparam int unsigned PAD_W = DATA_W - VIS_W;

  logic             ctrl_wr;
  logic             cnt_wr;
  kwdt_cmd_t        cmd;
  logic             open_q;
  logic             load_en;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             expire;

  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
  assign cnt_wr  = bus_we && (bus_addr == A_CNT);

  kwdt_keydec #(.DATA_W(DATA_W)) u_keydec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .wdata   (bus_wdata),
    .cmd     (cmd)
  );

  kwdt_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .cnt_wr  (cnt_wr),
    .open_q  (open_q),
    .load_en (load_en)
  );

  kwdt_counter #(.CNT_W(CNT_W), .VIS_W(VIS_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .cmd      (cmd),
    .load_en  (load_en),
    .load_val (bus_wdata[VIS_W-1:0]),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .expire   (expire)
  );

  kwdt_alarm u_alarm (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .cmd       (cmd),
    .irq_q     (wdt_irq),
    .rst_req_q (wdt_rst_req)
  );

  always_comb begin
    if (bus_addr == A_CNT) bus_rdata = {{PAD_W{1'b0}}, cnt_q[CNT_W-1:LOW_W]};
    else                   bus_rdata = '0;
  end

  // R3: a sealed count write does not touch the counter (no decrement that cycle)
  a_r3_sealed_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !open_q && !(run_q && tick_en) && !cmd.fill) |=> $stable(cnt_q));
  // R4: an open write always lands, low bits cleared
  a_r4_open_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && open_q) |=> (cnt_q[LOW_W-1:0] == '0));
  // R8: a reset request follows only a running counter
  a_r8_req_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_req) |-> (cnt_q == '0));
endmodule

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
  localparam logic [7:0]  A_CTRL = 8'h00;
  localparam logic [7:0]  A_CNT  = 8'h04;
  localparam logic [31:0] K_HALT = 32'h3877;
  localparam logic [31:0] K_RUN  = 32'h4A4B;
  localparam logic [31:0] K_OPEN = 32'hAB00;
  localparam logic [31:0] K_SEAL = 32'hAB01;
  localparam logic [31:0] K_FILL = 32'hDEAF;
  localparam logic [31:0] K_ACK  = 32'h7482;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h04;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_irq;
  logic        wdt_rst_req;

  int checks = 0;
  int errors = 0;

  // model state
  logic [19:0] m_cnt = 20'hFFFFF;
  bit m_run = 0, m_open = 0, m_irq = 0, m_rst = 0;

  always #2.5 clk = ~clk;

  kwdt_top dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    return (a == A_CNT) ? {16'h0, m_cnt[19:4]} : 32'h0;
  endfunction

  task automatic model_step(input bit we, input logic [7:0] a, input logic [31:0] d, input bit tk);
    bit key, ld, fill, step, exp;
    key  = we && a == A_CTRL && d[31:16] == 16'h0;
    ld   = we && a == A_CNT && m_open;
    fill = key && d == K_FILL;
    step = m_run && tk && m_cnt != 0 && !ld && !fill;
    exp  = step && m_cnt == 20'd1;
    if (ld)        m_cnt = {d[15:0], 4'h0};
    else if (fill) m_cnt = 20'hFFFFF;
    else if (step) m_cnt = m_cnt - 20'd1;
    if (key && d == K_HALT) m_run = 0;
    else if (key && d == K_RUN) m_run = 1;
    if (key && d == K_OPEN) m_open = 1;
    else if (key && d == K_SEAL) m_open = 0;
    m_rst = exp;
    if (exp) m_irq = 1;
    else if (key && d == K_ACK) m_irq = 0;
  endtask

  // One cycle: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d, input bit tk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(posedge clk);
    model_step(we, a, d, tk);
    @(negedge clk);
    chk(wdt_rst_req === m_rst, "R8 rst_req", {31'h0, wdt_rst_req}, {31'h0, m_rst});
    chk(wdt_irq === m_irq, "R9 irq", {31'h0, wdt_irq}, {31'h0, m_irq});
    chk(bus_rdata === exp_rd(a), "R5 readback", bus_rdata, exp_rd(a));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, a, d, 0);
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) cyc(0, A_CNT, 32'h0, tk);
  endtask

  task automatic expect_cnt(input logic [15:0] v, input string tag);
    cyc(0, A_CNT, 32'h0, 0);
    chk(bus_rdata === {16'h0, v}, tag, bus_rdata, {16'h0, v});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(wdt_irq === 0 && wdt_rst_req === 0, "R1 outputs", {30'h0, wdt_irq, wdt_rst_req}, 32'h0);
    chk(bus_rdata === 32'h0000FFFF, "R1 count", bus_rdata, 32'h0000FFFF);
    idle(5, 1);
    expect_cnt(16'hFFFF, "R1 halted after reset");

    // R3 sealed write; R10 keys with junk upper bits
    wr(A_CNT, 32'h0123);
    expect_cnt(16'hFFFF, "R3 sealed write ignored");
    wr(A_CTRL, 32'h0001AB00);
    wr(A_CNT, 32'h0042);
    expect_cnt(16'hFFFF, "R10 upper bits reject key");
    wr(A_CTRL, 32'h1234);
    wr(A_CTRL, 32'h0001DEAE);
    expect_cnt(16'hFFFF, "R10 unknown key");

    // R4 open write, R3 seal
    wr(A_CTRL, K_OPEN);
    wr(A_CNT, 32'hFFFF0042);
    expect_cnt(16'h0042, "R4 load");
    wr(A_CTRL, K_SEAL);
    wr(A_CNT, 32'h0099);
    expect_cnt(16'h0042, "R3 sealed again");

    // R7 / R2
    wr(A_CTRL, K_RUN);
    idle(32, 1);
    expect_cnt(16'h0040, "R7 32 ticks");
    idle(10, 0);
    expect_cnt(16'h0040, "R7 no tick no change");
    wr(A_CTRL, K_HALT);
    idle(48, 1);
    expect_cnt(16'h0040, "R2 halted");
    wr(A_CTRL, K_RUN);
    idle(16, 1);
    expect_cnt(16'h003F, "R2 resumed from held value");

    // R6 fill while sealed
    wr(A_CTRL, K_FILL);
    expect_cnt(16'hFFFF, "R6 fill");

    // R11 forced restart sequence
    wr(A_CTRL, K_HALT);
    wr(A_CTRL, K_OPEN);
    wr(A_CNT, 32'h1);
    wr(A_CTRL, K_SEAL);
    wr(A_CTRL, K_RUN);
    idle(15, 1);
    chk(wdt_rst_req === 0, "R11 not yet", {31'h0, wdt_rst_req}, 32'h0);
    idle(1, 1);
    chk(wdt_rst_req === 1, "R11 fires after 16 ticks", {31'h0, wdt_rst_req}, 32'h1);
    chk(wdt_irq === 1, "R8 irq set", {31'h0, wdt_irq}, 32'h1);
    idle(1, 1);
    chk(wdt_rst_req === 0, "R8 single pulse", {31'h0, wdt_rst_req}, 32'h0);
    idle(20, 1);
    expect_cnt(16'h0000, "R8 held at zero");

    // R9 ack, and set-wins
    wr(A_CTRL, K_ACK);
    chk(wdt_irq === 0, "R9 ack clears", {31'h0, wdt_irq}, 32'h0);
    wr(A_CTRL, K_OPEN);
    wr(A_CNT, 32'h1);
    wr(A_CTRL, K_SEAL);
    idle(15, 1);
    cyc(1, A_CTRL, K_ACK, 1);
    chk(wdt_irq === 1, "R9 expiry beats ack", {31'h0, wdt_irq}, 32'h1);

    // R8 zero load never fires
    wr(A_CTRL, K_ACK);
    wr(A_CTRL, K_OPEN);
    wr(A_CNT, 32'h0);
    idle(40, 1);
    chk(wdt_irq === 0, "R8 zero load silent", {31'h0, wdt_irq}, 32'h0);

    // constrained random mix, checked by the model inside cyc
    for (int n = 0; n < 6000; n++) begin
      int unsigned r;
      bit tk;
      r  = $urandom % 20;
      tk = ($urandom % 4) != 0;
      case (r)
        0:  cyc(1, A_CTRL, K_HALT, tk);
        1, 2: cyc(1, A_CTRL, K_RUN, tk);
        3, 4: cyc(1, A_CTRL, K_OPEN, tk);
        5:  cyc(1, A_CTRL, K_SEAL, tk);
        6:  cyc(1, A_CTRL, K_FILL, tk);
        7:  cyc(1, A_CTRL, K_ACK, tk);
        8, 9: cyc(1, A_CNT, {$urandom, 16'h0} | 32'($urandom % 4), tk);
        10: cyc(1, A_CNT, $urandom, tk);
        11: cyc(1, A_CTRL, $urandom, tk);
        12: cyc(0, A_CTRL, 32'h0, tk);
        13: cyc(0, 8'($urandom), 32'h0, tk);
        default: cyc(0, A_CNT, 32'h0, tk);
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule